// File: doc/BRIEF.md
# UART Interrupt Status and Masking Unit

This block collects interrupt events for a serial port and turns them into interrupt lines for a processor. Eleven single-cycle event pulses come in from the receive, transmit, receive-timeout, modem-status and line-error logic. Each pulse sets a sticky bit in a raw status register, and the bit stays set until software clears it. Software also programs a mask register. A raw bit only reaches the outputs while its mask bit is 1.

Software reaches the unit through a synchronous word-addressed register port. Writes take effect at the clock edge. Read data is returned combinationally for the offset presented. The masked status (raw AND mask) drives six level outputs: one combined line and five grouped lines for receive, transmit, timeout, modem status and errors. A core can therefore use the single combined line or route each group to its own handler.

Top module: `uart_irq_ctrl`

## Requirements
- R1: While the internal reset is active, and after it is released, the raw status and the mask are zero, every interrupt output is low and every register reads zero.
- R2: A 1 on bit k of `evt_set` at a clock edge sets raw status bit k. The bit stays set until it is cleared. Raw status reads back at word offset 15. Bit map: 10 overrun, 9 break, 8 parity, 7 framing, 6 receive timeout, 5 transmit, 4 receive, 3 DSR, 2 DCD, 1 CTS, 0 RI.
- R3: A write to word offset 17 clears every raw bit whose write-data bit is 1 and leaves every other raw bit unchanged. Offset 17 reads zero.
- R4: When an event pulse and a clear write hit the same raw bit in the same cycle, the bit ends up set.
- R5: A write to word offset 14 loads write-data bits 10:0 into the mask. Offset 14 reads the mask back, zero-extended.
- R6: Word offset 16 reads the raw status ANDed with the mask.
- R7: `irq_any` is high exactly when any masked status bit is 1.
- R8: `irq_rx`, `irq_tx` and `irq_rto` equal masked status bits 4, 5 and 6 respectively.
- R9: `irq_modem` is high exactly when any of masked bits 3:0 is 1.
- R10: `irq_err` is high exactly when any of masked bits 10:7 is 1.
- R11: Writes to offsets 15, 16 and unmapped offsets change neither register. Unmapped offsets read zero.
- R12: A change to raw status or mask caused at a clock edge appears on all six outputs and in the read data immediately after that same edge. No extra cycle of latency is added.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; release is synchronized internally |
| evt_set | input | 11 | Event pulses, one per raw status bit |
| reg_wen | input | 1 | Register write strobe |
| reg_addr | input | 6 | Register word offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| irq_any | output | 1 | Combined interrupt |
| irq_rx | output | 1 | Receive interrupt |
| irq_tx | output | 1 | Transmit interrupt |
| irq_rto | output | 1 | Receive-timeout interrupt |
| irq_modem | output | 1 | Modem-status interrupt |
| irq_err | output | 1 | Line-error interrupt |

## Verification
Every register update from an event pulse or a write lands at one clock edge. The outputs and the read data for the offset being presented reflect that update right after the edge, so each result is due one edge after its stimulus. The bench drives stimulus on the falling edge and advances its behavioural model at the following rising edge. It compares all seven outputs on the next falling edge, which is exactly one edge after the stimulus, and repeats this every cycle.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

  localparam int STAT_W = 11;
  localparam int NLINE  = 6;

  // raw status bit positions
  localparam int B_RI   = 0;
  localparam int B_CTS  = 1;
  localparam int B_DCD  = 2;
  localparam int B_DSR  = 3;
  localparam int B_RX   = 4;
  localparam int B_TX   = 5;
  localparam int B_RTO  = 6;
  localparam int B_FRM  = 7;
  localparam int B_PAR  = 8;
  localparam int B_BRK  = 9;
  localparam int B_OVR  = 10;

  // register word offsets
  localparam int OFS_MASK   = 14;
  localparam int OFS_RAW    = 15;
  localparam int OFS_MASKED = 16;
  localparam int OFS_CLR    = 17;

  typedef logic [STAT_W-1:0] stat_t;

  localparam stat_t SEL_ANY = '1;
  localparam stat_t SEL_RX  = stat_t'(1) << B_RX;
  localparam stat_t SEL_TX  = stat_t'(1) << B_TX;
  localparam stat_t SEL_RTO = stat_t'(1) << B_RTO;
  localparam stat_t SEL_MS  = (stat_t'(1) << B_RI) | (stat_t'(1) << B_CTS) |
                              (stat_t'(1) << B_DCD) | (stat_t'(1) << B_DSR);
  localparam stat_t SEL_ERR = (stat_t'(1) << B_FRM) | (stat_t'(1) << B_PAR) |
                              (stat_t'(1) << B_BRK) | (stat_t'(1) << B_OVR);

  // line index: 0 any, 1 rx, 2 tx, 3 rto, 4 modem, 5 err
  localparam logic [NLINE-1:0][STAT_W-1:0] LINE_SEL =
    {SEL_ERR, SEL_MS, SEL_RTO, SEL_TX, SEL_RX, SEL_ANY};

endpackage

// File: rtl/uart_irq_rst_sync.sv
module uart_irq_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/uart_irq_raw.sv
module uart_irq_raw #(
  parameter int W = 11
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_vec,
  input  logic [W-1:0] clr_vec,
  output logic [W-1:0] raw_q
);

  logic [W-1:0] raw_d;
  logic         raw_en;

  // set is applied after clear, so a coincident set wins
  always_comb begin
    raw_en = (|set_vec) | (|clr_vec);
    raw_d  = (raw_q & ~clr_vec) | set_vec;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      raw_q <= '0;
    end else if (raw_en) begin
      raw_q <= raw_d;
    end
  end

endmodule

// File: rtl/uart_irq_mask.sv
module uart_irq_mask #(
  parameter int W = 11
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic [W-1:0] mask_q
);

  logic [W-1:0] mask_d;

  always_comb begin
    mask_d = load ? load_val : mask_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
    end else if (load) begin
      mask_q <= mask_d;
    end
  end

endmodule

// File: rtl/uart_irq_fanout.sv
module uart_irq_fanout #(
  parameter int W  = 11,
  parameter int NL = 6,
  parameter logic [NL-1:0][W-1:0] SEL = '0
) (
  input  logic [W-1:0]  raw,
  input  logic [W-1:0]  mask,
  output logic [W-1:0]  masked,
  output logic [NL-1:0] lines
);

  assign masked = raw & mask;

  for (genvar g = 0; g < NL; g++) begin : g_line
    assign lines[g] = |(masked & SEL[g]);
  end

endmodule

// File: rtl/uart_irq_regif.sv
module uart_irq_regif
  import uart_irq_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 32
) (
  input  logic              wen,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  stat_t             raw,
  input  stat_t             mask,
  input  stat_t             masked,
  output logic              mask_load,
  output stat_t             mask_val,
  output stat_t             clr_vec,
  output logic [DATA_W-1:0] rdata
);

  localparam int PAD_W = DATA_W - STAT_W;

  logic hit_mask, hit_raw, hit_masked, hit_clr;
  stat_t rsel;
  logic unused_wdata_hi;

  always_comb begin
    hit_mask   = (addr == ADDR_W'(OFS_MASK));
    hit_raw    = (addr == ADDR_W'(OFS_RAW));
    hit_masked = (addr == ADDR_W'(OFS_MASKED));
    hit_clr    = (addr == ADDR_W'(OFS_CLR));

    mask_load = wen & hit_mask;
    mask_val  = wdata[STAT_W-1:0];
    clr_vec   = (wen & hit_clr) ? wdata[STAT_W-1:0] : '0;

    rsel = '0;
    if (hit_mask)   rsel = mask;
    if (hit_raw)    rsel = raw;
    if (hit_masked) rsel = masked;
    rdata = {{PAD_W{1'b0}}, rsel};
  end

  assign unused_wdata_hi = ^wdata[DATA_W-1:STAT_W];

endmodule

// File: rtl/uart_irq_ctrl.sv
module uart_irq_ctrl
  import uart_irq_pkg::*;
#(
  parameter int ADDR_W    = 6,
  parameter int DATA_W    = 32,
  parameter int RST_STAGE = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [10:0]       evt_set,
  input  logic              reg_wen,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq_any,
  output logic              irq_rx,
  output logic              irq_tx,
  output logic              irq_rto,
  output logic              irq_modem,
  output logic              irq_err
);

  logic              rst_sync_n;
  stat_t             raw_q;
  stat_t             mask_q;
  stat_t             masked;
  stat_t             clr_vec;
  stat_t             mask_val;
  logic              mask_load;
  logic [NLINE-1:0]  lines;

  uart_irq_rst_sync #(.STAGES(RST_STAGE)) rst_i (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  uart_irq_regif #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) regif_i (
    .wen(reg_wen), .addr(reg_addr), .wdata(reg_wdata),
    .raw(raw_q), .mask(mask_q), .masked(masked),
    .mask_load(mask_load), .mask_val(mask_val),
    .clr_vec(clr_vec), .rdata(reg_rdata)
  );

  uart_irq_raw #(.W(STAT_W)) raw_i (
    .clk(clk), .rst_n(rst_sync_n), .set_vec(evt_set),
    .clr_vec(clr_vec), .raw_q(raw_q)
  );

  uart_irq_mask #(.W(STAT_W)) mask_i (
    .clk(clk), .rst_n(rst_sync_n), .load(mask_load),
    .load_val(mask_val), .mask_q(mask_q)
  );

  uart_irq_fanout #(.W(STAT_W), .NL(NLINE), .SEL(LINE_SEL)) fan_i (
    .raw(raw_q), .mask(mask_q), .masked(masked), .lines(lines)
  );

  assign irq_any   = lines[0];
  assign irq_rx    = lines[1];
  assign irq_tx    = lines[2];
  assign irq_rto   = lines[3];
  assign irq_modem = lines[4];
  assign irq_err   = lines[5];

endmodule

// File: rtl/uart_irq_chk.sv
module uart_irq_chk
  import uart_irq_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic [10:0]       evt_set,
  input logic              reg_wen,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [DATA_W-1:0] reg_wdata,
  input logic [DATA_W-1:0] reg_rdata,
  input logic              irq_any,
  input logic              irq_modem,
  input logic              irq_err,
  input stat_t             raw_q,
  input stat_t             mask_q
);

  logic wr_clr, wr_mask, wr_ro;
  assign wr_clr  = reg_wen && (reg_addr == ADDR_W'(OFS_CLR));
  assign wr_mask = reg_wen && (reg_addr == ADDR_W'(OFS_MASK));
  assign wr_ro   = reg_wen && (reg_addr == ADDR_W'(OFS_RAW) || reg_addr == ADDR_W'(OFS_MASKED));

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    !rst_n |-> (raw_q == '0 && mask_q == '0 && !irq_any));

  // R2
  set_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt_set) |=> ((raw_q & $past(evt_set)) == $past(evt_set)));

  // R3
  clear_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_clr && evt_set == '0) |=> (raw_q == ($past(raw_q) & ~$past(reg_wdata[STAT_W-1:0]))));

  // R4
  set_beats_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_clr && |(evt_set & reg_wdata[STAT_W-1:0])) |=>
      ((raw_q & $past(evt_set)) == $past(evt_set)));

  // R5
  mask_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_mask |=> (mask_q == $past(reg_wdata[STAT_W-1:0])));

  // R7
  any_vs_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == ADDR_W'(OFS_MASKED)) |-> (irq_any == (reg_rdata != '0)));

  // R9
  modem_grp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_modem == (|(raw_q[3:0] & mask_q[3:0])));

  // R10
  err_grp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_err == (|(raw_q[10:7] & mask_q[10:7])));

  // R11
  ro_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ro && evt_set == '0) |=> ($stable(raw_q) && $stable(mask_q)));

endmodule

bind uart_irq_ctrl uart_irq_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) chk_i (
  .clk(clk), .rst_n(rst_sync_n), .evt_set(evt_set), .reg_wen(reg_wen),
  .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
  .irq_any(irq_any), .irq_modem(irq_modem), .irq_err(irq_err),
  .raw_q(raw_q), .mask_q(mask_q)
);

// File: tb/uart_irq_ctrl_tb_top.sv
`timescale 1ns/1ps
module uart_irq_ctrl_tb_top;

  logic        clk;
  logic        rst_n;
  logic [10:0] evt_set;
  logic        reg_wen;
  logic [5:0]  reg_addr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic irq_any, irq_rx, irq_tx, irq_rto, irq_modem, irq_err;

  int n_chk  = 0;
  int n_fail = 0;
  string cur_req = "R1";

  int m_raw  = 0;
  int m_mask = 0;

  uart_irq_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .evt_set(evt_set), .reg_wen(reg_wen),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq_any(irq_any), .irq_rx(irq_rx), .irq_tx(irq_tx), .irq_rto(irq_rto),
    .irq_modem(irq_modem), .irq_err(irq_err)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", cur_req, what, act, exp);
    end
  endtask

  task automatic compare_all();
    int masked;
    int exp_rd;
    masked = m_raw & m_mask;
    case (reg_addr)
      6'd14:   exp_rd = m_mask;
      6'd15:   exp_rd = m_raw;
      6'd16:   exp_rd = masked;
      default: exp_rd = 0;
    endcase
    chk("reg_rdata", int'(reg_rdata), exp_rd);
    chk("irq_any",   int'(irq_any),   int'(masked != 0));
    chk("irq_rx",    int'(irq_rx),    (masked >> 4) & 1);
    chk("irq_tx",    int'(irq_tx),    (masked >> 5) & 1);
    chk("irq_rto",   int'(irq_rto),   (masked >> 6) & 1);
    chk("irq_modem", int'(irq_modem), int'((masked & 'h00f) != 0));
    chk("irq_err",   int'(irq_err),   int'((masked & 'h780) != 0));
  endtask

  // one cycle: check previous edge's results, drive, then advance model
  task automatic step(input int ev, input bit we, input int a, input int d);
    int clr;
    @(negedge clk);
    compare_all();
    evt_set   = 11'(ev);
    reg_wen   = we;
    reg_addr  = 6'(a);
    reg_wdata = d;
    @(posedge clk);
    clr = 0;
    if (we && a == 14) m_mask = d & 'h7ff;
    if (we && a == 17) clr = d & 'h7ff;
    m_raw = ((m_raw & ~clr) | ev) & 'h7ff;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0;
    evt_set = '0; reg_wen = 1'b0; reg_addr = 6'd15; reg_wdata = '0;
    // R1: outputs and reads during and after reset
    cur_req = "R1";
    repeat (3) @(posedge clk);
    @(negedge clk);
    compare_all();
    rst_n = 1'b1;
    for (int a = 14; a <= 17; a++) step(0, 0, a, 0);
    step(0, 0, 15, 0);

    // R5: mask load and readback, upper data ignored
    cur_req = "R5";
    step(0, 1, 14, 32'hffff_f5a5);
    step(0, 0, 14, 0);
    step(0, 1, 14, 32'h0000_0000);
    step(0, 0, 14, 0);

    // R2: sticky event bits
    cur_req = "R2";
    step('h001, 0, 15, 0);
    step('h400, 0, 15, 0);
    step(0, 0, 15, 0);
    step(0, 0, 15, 0);

    // R6: masked status read
    cur_req = "R6";
    step(0, 1, 14, 'h3f0);
    step(0, 0, 16, 0);
    step('h0ff, 0, 16, 0);
    step(0, 0, 16, 0);

    // R7..R10: each group alone
    cur_req = "R7";
    step(0, 1, 17, 'h7ff);
    step(0, 1, 14, 'h7ff);
    step(0, 0, 16, 0);
    cur_req = "R8";
    for (int b = 4; b <= 6; b++) begin
      step(1 << b, 0, 16, 0);
      step(0, 1, 17, 1 << b);
    end
    cur_req = "R9";
    for (int b = 0; b <= 3; b++) begin
      step(1 << b, 0, 16, 0);
      step(0, 1, 17, 1 << b);
    end
    cur_req = "R10";
    for (int b = 7; b <= 10; b++) begin
      step(1 << b, 0, 16, 0);
      step(0, 1, 17, 1 << b);
    end
    step('h780, 1, 14, 'h07f);
    step(0, 0, 16, 0);

    // R3: partial clear, clear register reads zero
    cur_req = "R3";
    step('h7ff, 1, 14, 'h7ff);
    step(0, 1, 17, 'h0a5);
    step(0, 0, 15, 0);
    step(0, 0, 17, 0);

    // R4: set and clear on the same bits
    cur_req = "R4";
    step('h010, 1, 17, 'h7ff);
    step(0, 0, 15, 0);
    step('h300, 1, 17, 'h300);
    step(0, 0, 15, 0);

    // R11: writes to read-only and unmapped offsets
    cur_req = "R11";
    step(0, 1, 15, 'h7ff);
    step(0, 1, 16, 'h000);
    step(0, 1, 0, 'h7ff);
    step(0, 1, 63, 'h7ff);
    step(0, 0, 15, 0);
    step(0, 0, 14, 0);
    step(0, 0, 5, 0);

    // R12: random traffic, outputs compared one edge after each stimulus
    cur_req = "R12";
    for (int i = 0; i < 400; i++) begin
      int ev;
      int a;
      ev = ($urandom % 4 == 0) ? int'($urandom & 'h7ff) : 0;
      a  = 13 + int'($urandom % 6);
      step(ev, ($urandom % 3) == 0, a, int'($urandom));
    end
    step(0, 0, 16, 0);
    @(negedge clk);
    compare_all();
    finish_run();
  end

endmodule